// File: doc/BRIEF.md
# Shared Mailbox Array with Interrupts

This block holds a bank of single-word mailboxes through which one processor (the producer) hands a 32-bit message to another (the consumer). The top bit of each mailbox word is its full flag: the producer posts a message by writing the payload with that bit set, and the consumer frees the mailbox by writing zero over the whole word. The payload and the flag live in one register, so a single bus write is enough to post or to release a message.

Every mailbox presents two level conditions, "holding a message" (full) and "free" (empty). These are packed into one status word and compared against a separate enable register for each shared interrupt line. A line is raised while any enabled condition holds. An enabled empty condition therefore keeps the line high for as long as the mailbox sits idle. Software is expected to enable the empty condition only while it is waiting for the consumer to drain a posted message. Optional per-mailbox enables can gate each condition before it reaches the status word. A read-only capability word reports how many mailboxes and interrupt lines the instance has.

Top module: `shared_mbox_array`

## Requirements
- R1: After reset every mailbox word, every local enable and every line enable reads zero, and all interrupt lines are low.
- R2: A write to the data word of mailbox i (byte address 0x10000 + i*0x8000) stores all 32 bits. Bit 31 set marks the mailbox full, and the stored word reads back unchanged.
- R3: Writing zero to a mailbox data word clears both the full flag and the payload, and the mailbox reads as empty again.
- R4: The raw status word at 0x304 carries, for each present mailbox i, the free condition in bit i and the holding condition in bit 8+i. All other bits read zero.
- R5: The per-mailbox holding-enable sits at window offset 0x04 and the free-enable at window offset 0x08, each in bit 0. They reset to 0 and read back. Bit i of the status word is (not full AND free-enable) and bit 8+i is (full AND holding-enable).
- R6: Interrupt line n has its enable register at 0x100 + 4*n. Bits 15:0 are writable and bits 31:16 read zero.
- R7: Line n is a registered level. It is high in the cycle after (status AND enable n) is nonzero and stays high while that holds, including for an idle free mailbox.
- R8: The vector register at 0x300 reads the current interrupt lines in bits N_LINES-1:0, with zeros above.
- R9: The capability word at 0x380 reads the mailbox count in bits 3:0 and the line count in bits 19:16. Its semaphore and doorbell count fields (7:4, 11:8, 15:12) read zero.
- R10: A read returns its data with rsp_valid one cycle after the request, and rsp_valid is low otherwise. Unmapped addresses, including the windows of absent mailboxes, read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq | output | N_LINES | Shared interrupt lines, level |

## Verification
The assertions assume a single-beat bus: each request is seen for one cycle, and reads and writes use word-aligned byte addresses. The post and clear properties also assume that the window decode is the only source of mailbox updates. The interrupt property assumes that enable and status are sampled on the same edge as the line register. The stimulus drives requests for one cycle at the falling edge and picks addresses from the mapped set plus a few unmapped words. It waits for each interrupt update before reading the vector, so every access it makes stays inside these assumptions.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DATA_W      = 32;
    localparam int FLAG_BIT    = 31;
    localparam int STAT_HALF   = 8;
    localparam int STAT_W      = 2 * STAT_HALF;
    localparam int WIN_SHIFT   = 15;
    localparam int WIN_FIRST   = 2;
    localparam int CTL_OFF_W   = 12;
    localparam logic [11:0] OFF_LINE_EN = 12'h100;
    localparam logic [11:0] OFF_VECTOR  = 12'h300;
    localparam logic [11:0] OFF_RAW     = 12'h304;
    localparam logic [11:0] OFF_CAPS    = 12'h380;
    localparam int SLOT_DATA   = 0;
    localparam int SLOT_HOLD_EN = 4;
    localparam int SLOT_FREE_EN = 8;

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              hold_en;
        logic              free_en;
    } slot_t;

    function automatic logic [DATA_W-1:0] caps_word(input int n_mbox, input int n_lines);
        logic [DATA_W-1:0] v;
        v        = '0;
        v[3:0]   = 4'(n_mbox);
        v[19:16] = 4'(n_lines);
        return v;
    endfunction
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot
    import mbx_pkg::*;
#(
    parameter bit LOCAL_IE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_word,
    input  logic              we_hold,
    input  logic              we_free,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] word_o,
    output logic              hold_en_o,
    output logic              free_en_o,
    output logic              full_o,
    output logic              hold_req_o,
    output logic              free_req_o
);
    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_word) s_d.word = wdata;
        if (LOCAL_IE) begin
            if (we_hold) s_d.hold_en = wdata[0];
            if (we_free) s_d.free_en = wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_o = s_q.word;
    assign full_o = s_q.word[FLAG_BIT];

    generate
        if (LOCAL_IE) begin : g_gate
            assign hold_en_o  = s_q.hold_en;
            assign free_en_o  = s_q.free_en;
            assign hold_req_o = full_o & s_q.hold_en;
            assign free_req_o = ~full_o & s_q.free_en;
        end else begin : g_nogate
            assign hold_en_o  = 1'b0;
            assign free_en_o  = 1'b0;
            assign hold_req_o = full_o;
            assign free_req_o = ~full_o;
        end
    endgenerate
endmodule

// File: rtl/mbx_line_mask.sv
module mbx_line_mask
    import mbx_pkg::*;
#(
    parameter int N_LINES = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [STAT_W-1:0]              stat,
    input  logic [N_LINES-1:0][STAT_W-1:0] line_en,
    output logic [N_LINES-1:0]             irq_o
);
    logic [N_LINES-1:0] irq_d, irq_q;

    always_comb begin
        for (int n = 0; n < N_LINES; n++) begin
            irq_d[n] = |(stat & line_en[n]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/shared_mbox_array.sv
module shared_mbox_array
    import mbx_pkg::*;
#(
    parameter int N_MBOX   = 8,
    parameter int N_LINES  = 4,
    parameter int ADDR_W   = 20,
    parameter bit LOCAL_IE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic [N_LINES-1:0] irq
);
    localparam int WIN_W = ADDR_W - WIN_SHIFT;

    typedef struct packed {
        logic [N_LINES-1:0][STAT_W-1:0] line_en;
        logic [DATA_W-1:0]              rdata;
        logic                           rvalid;
    } regs_t;

    regs_t r_d, r_q;

    logic [WIN_W-1:0]     win;
    logic [WIN_SHIFT-1:0] woff;
    logic                 ctl_hit;
    logic [CTL_OFF_W-1:0] coff;
    logic                 do_wr, do_rd;

    logic [N_MBOX-1:0]              slot_hit;
    logic [N_MBOX-1:0]              we_word, we_hold, we_free;
    logic [N_MBOX-1:0][DATA_W-1:0]  s_word;
    logic [N_MBOX-1:0]              s_hold_en, s_free_en;
    logic [N_MBOX-1:0]              full_w, hold_req, free_req;
    logic [STAT_W-1:0]              stat_w;
    logic [N_LINES-1:0][STAT_W-1:0] line_en_q;
    logic [DATA_W-1:0]              rd_mux;

    assign win     = req_addr[ADDR_W-1:WIN_SHIFT];
    assign woff    = req_addr[WIN_SHIFT-1:0];
    assign ctl_hit = (win == '0) && (woff[WIN_SHIFT-1:CTL_OFF_W] == '0);
    assign coff    = woff[CTL_OFF_W-1:0];
    assign do_wr   = req_valid & req_write;
    assign do_rd   = req_valid & ~req_write;

    generate
        for (genvar i = 0; i < N_MBOX; i++) begin : g_slot
            assign slot_hit[i] = (win == WIN_W'(WIN_FIRST + i));
            assign we_word[i]  = do_wr & slot_hit[i] & (woff == WIN_SHIFT'(SLOT_DATA));
            assign we_hold[i]  = do_wr & slot_hit[i] & (woff == WIN_SHIFT'(SLOT_HOLD_EN));
            assign we_free[i]  = do_wr & slot_hit[i] & (woff == WIN_SHIFT'(SLOT_FREE_EN));

            mbx_slot #(.LOCAL_IE(LOCAL_IE)) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .we_word    (we_word[i]),
                .we_hold    (we_hold[i]),
                .we_free    (we_free[i]),
                .wdata      (req_wdata),
                .word_o     (s_word[i]),
                .hold_en_o  (s_hold_en[i]),
                .free_en_o  (s_free_en[i]),
                .full_o     (full_w[i]),
                .hold_req_o (hold_req[i]),
                .free_req_o (free_req[i])
            );
        end
    endgenerate

    always_comb begin
        stat_w = '0;
        for (int i = 0; i < N_MBOX; i++) begin
            stat_w[i]             = free_req[i];
            stat_w[STAT_HALF + i] = hold_req[i];
        end
    end

    assign line_en_q = r_q.line_en;

    mbx_line_mask #(.N_LINES(N_LINES)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat    (stat_w),
        .line_en (line_en_q),
        .irq_o   (irq)
    );

    always_comb begin
        rd_mux = '0;
        if (ctl_hit) begin
            if (coff == OFF_VECTOR) rd_mux = DATA_W'(irq);
            if (coff == OFF_RAW)    rd_mux = DATA_W'(stat_w);
            if (coff == OFF_CAPS)   rd_mux = caps_word(N_MBOX, N_LINES);
            for (int n = 0; n < N_LINES; n++) begin
                if (coff == CTL_OFF_W'(OFF_LINE_EN + 4 * n)) rd_mux = DATA_W'(r_q.line_en[n]);
            end
        end
        for (int i = 0; i < N_MBOX; i++) begin
            if (slot_hit[i]) begin
                if (woff == WIN_SHIFT'(SLOT_DATA))    rd_mux = s_word[i];
                if (woff == WIN_SHIFT'(SLOT_HOLD_EN)) rd_mux = DATA_W'(s_hold_en[i]);
                if (woff == WIN_SHIFT'(SLOT_FREE_EN)) rd_mux = DATA_W'(s_free_en[i]);
            end
        end
    end

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = do_rd;
        if (do_rd) r_d.rdata = rd_mux;
        if (do_wr && ctl_hit) begin
            for (int n = 0; n < N_LINES; n++) begin
                if (coff == CTL_OFF_W'(OFF_LINE_EN + 4 * n)) r_d.line_en[n] = req_wdata[STAT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid = r_q.rvalid;
    assign rsp_rdata = r_q.rdata;
endmodule

// File: rtl/shared_mbox_array_chk.sv
module shared_mbox_array_chk
    import mbx_pkg::*;
#(
    parameter int N_MBOX  = 8,
    parameter int N_LINES = 4,
    parameter int ADDR_W  = 20
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           req_valid,
    input logic                           req_write,
    input logic [ADDR_W-1:0]              req_addr,
    input logic [31:0]                    req_wdata,
    input logic                           rsp_valid,
    input logic [N_LINES-1:0]             irq,
    input logic [STAT_W-1:0]              stat_w,
    input logic [N_LINES-1:0][STAT_W-1:0] line_en_q,
    input logic [N_MBOX-1:0]              full_w
);
    logic [N_LINES-1:0] want_irq;

    always_comb begin
        for (int n = 0; n < N_LINES; n++) want_irq[n] = |(stat_w & line_en_q[n]);
    end

    // R7: each line follows its masked status one cycle later
    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == $past(want_irq));

    // R10: read response exactly one cycle after a read request
    assert_rsp_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    assert_no_stray_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R4: the holding half of the status never shows an empty mailbox
    generate
        for (genvar k = 0; k < N_MBOX; k++) begin : g_slot_chk
            localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'((WIN_FIRST + k) << WIN_SHIFT);

            // R2 and R3: flag follows bit 31 of the last data write
            assert_post_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && req_write && req_addr == DATA_ADDR) |=> full_w[k] == $past(req_wdata[31]));

            assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !(req_valid && req_write && req_addr == DATA_ADDR) |=> $stable(full_w[k]));

            assert_hold_needs_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
                stat_w[STAT_HALF + k] |-> full_w[k]);

            assert_free_needs_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
                stat_w[k] |-> !full_w[k]);
        end
    endgenerate
endmodule

bind shared_mbox_array shared_mbox_array_chk #(
    .N_MBOX  (N_MBOX),
    .N_LINES (N_LINES),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .irq       (irq),
    .stat_w    (stat_w),
    .line_en_q (line_en_q),
    .full_w    (full_w)
);

// File: tb/sim_shared_mbox_array.sv
module sim_shared_mbox_array;
    localparam int NM = 8;
    localparam int NL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [NL-1:0] irq;

    int total = 0;
    int bad = 0;

    logic [31:0] m_data [NM];
    logic        m_hold [NM];
    logic        m_free [NM];
    logic [15:0] m_len  [NL];

    always #4 clk = ~clk;

    shared_mbox_array u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .irq(irq)
    );

    function automatic logic [19:0] mb_addr(input int i, input int off);
        return 20'(32'h10000 + i * 32'h8000 + off);
    endfunction

    function automatic logic [15:0] m_stat();
        logic [15:0] s = '0;
        for (int i = 0; i < NM; i++) begin
            if (!m_data[i][31] && m_free[i]) s[i] = 1'b1;
            if (m_data[i][31] && m_hold[i])  s[8+i] = 1'b1;
        end
        return s;
    endfunction

    function automatic logic [NL-1:0] m_irq();
        logic [NL-1:0] v;
        for (int n = 0; n < NL; n++) v[n] = |(m_stat() & m_len[n]);
        return v;
    endfunction

    function automatic logic [31:0] exp_read(input logic [19:0] a);
        int win = int'(a >> 15);
        int off = int'(a[14:0]);
        if (win == 0) begin
            if (off == 'h300) return 32'(m_irq());
            if (off == 'h304) return 32'(m_stat());
            if (off == 'h380) return 32'h0004_0008;
            if (off >= 'h100 && off < 'h100 + 4*NL && off[1:0] == 2'b00) return 32'(m_len[(off-'h100)/4]);
            return 32'h0;
        end
        if (win >= 2 && win < 2 + NM) begin
            if (off == 0) return m_data[win-2];
            if (off == 4) return 32'(m_hold[win-2]);
            if (off == 8) return 32'(m_free[win-2]);
        end
        return 32'h0;
    endfunction

    function automatic void model_write(input logic [19:0] a, input logic [31:0] d);
        int win = int'(a >> 15);
        int off = int'(a[14:0]);
        if (win == 0 && off >= 'h100 && off < 'h100 + 4*NL && off[1:0] == 2'b00) m_len[(off-'h100)/4] = d[15:0];
        if (win >= 2 && win < 2 + NM) begin
            if (off == 0) m_data[win-2] = d;
            if (off == 4) m_hold[win-2] = d[0];
            if (off == 8) m_free[win-2] = d[0];
        end
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_check(input string tag, input logic [19:0] a);
        logic [31:0] e;
        e = exp_read(a);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R10 rsp_valid"}, 32'(rsp_valid), 32'h1);
        check(tag, rsp_rdata, e);
    endtask

    task automatic settle_check(input string tag);
        @(negedge clk);
        check({tag, " R7 irq"}, 32'(irq), 32'(m_irq()));
        rd_check({tag, " R4 status"}, 20'h00304);
        rd_check({tag, " R8 vector"}, 20'h00300);
    endtask

    function automatic logic [19:0] rand_addr();
        int k = int'($urandom % 12);
        int offs [4] = '{0, 4, 8, 'hC};
        if (k < 8) return mb_addr(k, offs[$urandom % 4]);
        if (k == 8) return 20'(32'h100 + 4 * ($urandom % 5));
        if (k == 9) return 20'h00380;
        if (k == 10) return mb_addr(8, 0);
        return 20'h00200;
    endfunction

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NM; i++) begin m_data[i] = '0; m_hold[i] = 0; m_free[i] = 0; end
        for (int n = 0; n < NL; n++) m_len[n] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq after reset", 32'(irq), 32'h0);
        for (int i = 0; i < NM; i++) begin
            rd_check("R1 mailbox word", mb_addr(i, 0));
            rd_check("R1 hold enable", mb_addr(i, 4));
        end
        for (int n = 0; n < NL; n++) rd_check("R1 line enable", 20'(32'h100 + 4*n));
        // R9 capability
        rd_check("R9 caps", 20'h00380);
        // R6 upper bits of a line enable
        wr(20'h00104, 32'hFFFF_FFFF);
        rd_check("R6 line enable mask", 20'h00104);
        wr(20'h00104, 32'h0);

        // R2 post / R3 clear on mailbox 5 with both local enables
        wr(mb_addr(5, 4), 32'h1);
        wr(mb_addr(5, 8), 32'h1);
        rd_check("R5 hold enable readback", mb_addr(5, 4));
        wr(mb_addr(5, 0), 32'h8000_ABCD);
        rd_check("R2 posted word", mb_addr(5, 0));
        settle_check("R2 posted");
        wr(mb_addr(5, 0), 32'h0);
        rd_check("R3 cleared word", mb_addr(5, 0));
        settle_check("R3 cleared");

        // R7 idle free mailbox keeps line 1 high
        wr(20'h00104, 32'h0000_0020);
        @(negedge clk);
        for (int c = 0; c < 5; c++) begin
            check("R7 idle free level", 32'(irq[1]), 32'h1);
            @(negedge clk);
        end
        // posting drops it the cycle after
        wr(mb_addr(5, 0), 32'h8000_0001);
        check("R7 still high at write cycle", 32'(irq[1]), 32'h1);
        @(negedge clk);
        check("R7 drop after post", 32'(irq[1]), 32'h0);
        // R10 absent window and unmapped words ignore writes
        wr(mb_addr(8, 0), 32'hDEAD_BEEF);
        rd_check("R10 absent window", mb_addr(8, 0));
        wr(20'h00200, 32'h1234_5678);
        rd_check("R10 unmapped", 20'h00200);
        rd_check("R10 gap offset", mb_addr(2, 'hC));

        // constrained random
        for (int it = 0; it < 600; it++) begin
            int op = int'($urandom % 7);
            int j  = int'($urandom % NM);
            case (op)
                0: wr(mb_addr(j, 0), $urandom | 32'h8000_0000);
                1: wr(mb_addr(j, 0), 32'h0);
                2: wr(mb_addr(j, 0), $urandom & 32'h7FFF_FFFF);
                3: wr(mb_addr(j, 4), $urandom);
                4: wr(mb_addr(j, 8), $urandom);
                5: wr(20'(32'h100 + 4 * ($urandom % NL)), $urandom);
                default: wr(rand_addr(), $urandom);
            endcase
            settle_check("random");
            rd_check("random read R5", rand_addr());
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule